// File: doc/BRIEF.md
# Configuration address translator

This block turns a processor access that falls inside the configuration window into a type-0 PCI configuration address. The requester supplies the 16-bit offset of the access within the window. A mapping word supplies the upper 16 address bits and also holds a bit that switches the window off. The combined 32-bit address carries a one-hot device-select field in its upper bits. The block converts that field to a device number by finding its lowest set bit. It also extracts the function and register numbers, adds the bus number input, and issues an enabled configuration word to the configuration bus that follows.

Results come out one cycle after the request. When the window is off, writes are dropped and reads are answered locally with all ones for the access size. When the device-select field is all zeros, the block reports an error and issues nothing downstream. Read responses from the downstream bus are passed back to the requester.

The block also keeps the bridge's two received-abort status bits. The downstream side sets them. The block clears them after every access that it translates.

Top module: `cfgx_translator`

## Requirements
- R1: While reset is low, and in the first cycle after reset, every output is zero: cfg_valid, cfg_err, rsp_valid, cfg_addr, rsp_data and abort_stat.
- R2: The effective address is {map_cfg[15:0], req_off[15:0]}. One cycle after an accepted request, cfg_valid pulses for one cycle with a cfg_addr laid out as follows:
  - bit 31 is 1 and bits 30:24 are 0;
  - bits 23:16 hold bus_num;
  - bits 15:11 hold the device number;
  - bits 10:8 hold effective address bits 10:8 (function);
  - bits 7:0 hold effective address bits 7:0 (register).
- R3: The device number is the index, from 0 to 20, of the lowest set bit of the device-select field, which is effective address bits 31:11. Bits of map_cfg above bit 16 are ignored.
- R4: When map_cfg[16] is 1, the window is off. A write issues no cfg_valid, no cfg_err and no rsp_valid. A read gets rsp_valid one cycle later, and its rsp_data is all ones for the size, with the upper bits zero:
  - size code 0 (1 byte) gives 0x000000FF;
  - size code 1 (2 bytes) gives 0x0000FFFF;
  - size codes 2 and 3 (4 bytes) give 0xFFFFFFFF.
- R5: When the window is on and the device-select field is zero, cfg_err pulses high for exactly one cycle, one cycle after the request, and cfg_valid stays low. A read in this case also gets the all-ones response of R4.
- R6: cfg_small is 1 together with cfg_valid when req_off[1:0] is not zero, and 0 when it is zero.
- R7: cfg_write, cfg_size and cfg_wdata carry req_write, req_size and req_wdata of the translated request.
- R8: A downstream read response (dn_rvalid with dn_rdata) appears as rsp_valid with the same rsp_data one cycle later.
- R9: abort_stat bit 0 records a received master abort and bit 1 a received target abort.
  - The bits are set by mabort_set and tabort_set and stay set.
  - Both bits clear at the clock edge that ends a cfg_valid cycle, and this clear wins over a set in the same cycle.
  - Accesses in an off window and accesses with a zero device select do not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_off | input | 16 | Offset of the access within the window |
| req_wdata | input | 32 | Write data |
| map_cfg | input | 32 | Mapping word: bits 15:0 upper address, bit 16 window off |
| bus_num | input | 8 | Bus number placed in the configuration word |
| dn_rvalid | input | 1 | Downstream read data valid |
| dn_rdata | input | 32 | Downstream read data |
| mabort_set | input | 1 | Sets the received-master-abort bit |
| tabort_set | input | 1 | Sets the received-target-abort bit |
| cfg_valid | output | 1 | Configuration access issued |
| cfg_write | output | 1 | Issued access is a write |
| cfg_addr | output | 32 | Enabled configuration address word |
| cfg_size | output | 2 | Size code of the issued access |
| cfg_wdata | output | 32 | Write data of the issued access |
| cfg_small | output | 1 | Issued access has a sub-word offset |
| cfg_err | output | 1 | One-cycle pulse: device select was zero |
| rsp_valid | output | 1 | Read response to the requester |
| rsp_data | output | 32 | Read response data |
| abort_stat | output | 2 | Received abort bits: bit 0 master, bit 1 target |

## Verification
The hardest case to reach is a status set that arrives in the same cycle the clear takes effect. For it, the stimulus raises mabort_set and tabort_set exactly in the cycle that cfg_valid is high, so that the clear must win. A second case is the lowest-set-bit rule. It only shows when several device-select bits are set at once and those bits come from both the mapping word and the offset, so the vectors combine the two sources. The off-window and zero-select paths are driven with every size code and both directions. The bench then confirms that nothing reaches the downstream outputs and that the status bits survive.

// File: rtl/cfgx_pkg.sv
// Shared widths, size codes and helpers for the configuration address translator.
// Assumes a 32-bit configuration address and a 32-bit data path.
package cfgx_pkg;
    localparam int ADDR_W    = 32;
    localparam int DATA_W    = 32;
    localparam int OFF_W     = 16;
    localparam int SEL_LSB   = 11;
    localparam int SEL_W     = ADDR_W - SEL_LSB;
    localparam int DEV_W     = $clog2(SEL_W);
    localparam int FUNC_W    = 3;
    localparam int REG_W     = 8;
    localparam int BUS_W     = 8;
    localparam int OFF_BIT   = 16;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WRD2 = 2'd3
    } size_e;

    // All-ones read value for the given size code, upper bits zero.
    function automatic logic [DATA_W-1:0] size_ones(input logic [1:0] sz);
        logic [DATA_W-1:0] v;
        case (sz)
            SZ_BYTE: v = {{(DATA_W-8){1'b0}}, 8'hFF};
            SZ_HALF: v = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: v = {DATA_W{1'b1}};
        endcase
        return v;
    endfunction
endpackage

// File: rtl/cfgx_sel_enc.sv
// Lowest-set-bit encoder for the one-hot device-select field.
// Assumes any number of bits may be set; the lowest index wins.
// hit is low when the field is all zeros, and idx is then zero.
module cfgx_sel_enc #(
    parameter int IN_W  = 21,
    parameter int IDX_W = $clog2(IN_W)
) (
    input  logic [IN_W-1:0]  sel,
    output logic [IDX_W-1:0] idx,
    output logic             hit
);
    logic [IN_W-1:0] below_clear;

    // Flag per bit: every lower bit of the field is clear.
    genvar g;
    generate
        for (g = 0; g < IN_W; g++) begin : g_below
            if (g == 0) begin : g_first
                assign below_clear[g] = 1'b1;
            end else begin : g_rest
                assign below_clear[g] = ~|sel[g-1:0];
            end
        end
    endgenerate

    // Encode the single bit that is set with all lower bits clear.
    always_comb begin
        idx = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (sel[i] && below_clear[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign hit = |sel;
endmodule

// File: rtl/cfgx_word_fmt.sv
// Builds the enabled type-0 configuration word from bus, device,
// function and register numbers. Purely combinational.
module cfgx_word_fmt
    import cfgx_pkg::*;
(
    input  logic [BUS_W-1:0]  bus,
    input  logic [DEV_W-1:0]  dev,
    input  logic [FUNC_W-1:0] func,
    input  logic [REG_W-1:0]  regn,
    output logic [ADDR_W-1:0] word
);
    localparam int PAD_W = ADDR_W - 1 - BUS_W - DEV_W - FUNC_W - REG_W;

    // Pack the fields with the enable bit at the top.
    always_comb begin
        word = {1'b1, {PAD_W{1'b0}}, bus, dev, func, regn};
    end
endmodule

// File: rtl/cfgx_abort_stat.sv
// Sticky received-abort bits: bit 0 master abort, bit 1 target abort.
// A clear request wins over a set arriving in the same cycle.
module cfgx_abort_stat (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set_master,
    input  logic       set_target,
    output logic [1:0] stat
);
    // Hold, set or clear the two status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat <= 2'b00;
        end else if (clr) begin
            stat <= 2'b00;
        end else begin
            stat <= stat | {set_target, set_master};
        end
    end
endmodule

// File: rtl/cfgx_translator.sv
// Configuration address translator, top level.
// Takes one access per req_valid cycle and answers one cycle later.
// Assumes the requester keeps at most one read outstanding, so a local
// all-ones answer and a downstream response never fall in the same cycle.
module cfgx_translator
    import cfgx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [31:0]       map_cfg,
    input  logic [BUS_W-1:0]  bus_num,
    input  logic              dn_rvalid,
    input  logic [DATA_W-1:0] dn_rdata,
    input  logic              mabort_set,
    input  logic              tabort_set,
    output logic              cfg_valid,
    output logic              cfg_write,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [1:0]        cfg_size,
    output logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_small,
    output logic              cfg_err,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        abort_stat
);
    logic [ADDR_W-1:0] eff_addr;
    logic              win_off;
    logic [DEV_W-1:0]  dev_num;
    logic              sel_hit;
    logic [ADDR_W-1:0] word;
    logic              do_issue;
    logic              do_err;
    logic              do_ones;

    // Effective address: upper half from the mapping word.
    always_comb begin
        eff_addr = {map_cfg[ADDR_W-OFF_W-1:0], req_off};
        win_off  = map_cfg[OFF_BIT];
    end

    cfgx_sel_enc #(.IN_W(SEL_W), .IDX_W(DEV_W)) u_enc (
        .sel (eff_addr[ADDR_W-1:SEL_LSB]),
        .idx (dev_num),
        .hit (sel_hit)
    );

    cfgx_word_fmt u_fmt (
        .bus  (bus_num),
        .dev  (dev_num),
        .func (eff_addr[SEL_LSB-1:REG_W]),
        .regn (eff_addr[REG_W-1:0]),
        .word (word)
    );

    // Classify the request: issue, error, or local all-ones answer.
    always_comb begin
        do_issue = req_valid && !win_off && sel_hit;
        do_err   = req_valid && !win_off && !sel_hit;
        do_ones  = req_valid && !req_write && (win_off || !sel_hit);
    end

    // Register the downstream request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_valid <= 1'b0;
            cfg_write <= 1'b0;
            cfg_addr  <= '0;
            cfg_size  <= '0;
            cfg_wdata <= '0;
            cfg_small <= 1'b0;
        end else begin
            cfg_valid <= do_issue;
            if (do_issue) begin
                cfg_write <= req_write;
                cfg_addr  <= word;
                cfg_size  <= req_size;
                cfg_wdata <= req_wdata;
                cfg_small <= |req_off[1:0];
            end
        end
    end

    // One-cycle error pulse for a zero device select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_err <= 1'b0;
        end else begin
            cfg_err <= do_err;
        end
    end

    // Read response: local all-ones answer or downstream data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= do_ones || dn_rvalid;
            if (do_ones) begin
                rsp_data <= size_ones(req_size);
            end else if (dn_rvalid) begin
                rsp_data <= dn_rdata;
            end
        end
    end

    cfgx_abort_stat u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (cfg_valid),
        .set_master (mabort_set),
        .set_target (tabort_set),
        .stat       (abort_stat)
    );
endmodule

// File: rtl/cfgx_translator_chk.sv
// Property checker for cfgx_translator, attached through bind.
// Observes ports only.
module cfgx_translator_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic [31:0] map_cfg,
    input logic        cfg_valid,
    input logic [31:0] cfg_addr,
    input logic        cfg_err,
    input logic        rsp_valid,
    input logic [31:0] rsp_data,
    input logic [1:0]  abort_stat
);
    assert_enable_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_addr[31:24] == 8'h80);

    assert_issue_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> $past(req_valid));

    assert_dev_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> cfg_addr[15:11] <= 5'd20);

    assert_off_window_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && map_cfg[16]) |=> (!cfg_valid && !cfg_err));

    assert_off_byte_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && map_cfg[16] && !req_write && req_size == 2'd0)
            |=> (rsp_valid && rsp_data == 32'h0000_00FF));

    assert_err_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> !cfg_valid);

    assert_err_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(req_valid && !map_cfg[16]));

    assert_clear_after_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |=> abort_stat == 2'b00);
endmodule

bind cfgx_translator cfgx_translator_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_size   (req_size),
    .map_cfg    (map_cfg),
    .cfg_valid  (cfg_valid),
    .cfg_addr   (cfg_addr),
    .cfg_err    (cfg_err),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data),
    .abort_stat (abort_stat)
);

// File: tb/cfgx_translator_test.sv
module cfgx_translator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'd0;
    logic [15:0] req_off = 16'h0;
    logic [31:0] req_wdata = 32'h0;
    logic [31:0] map_cfg = 32'h0;
    logic [7:0]  bus_num = 8'h0;
    logic        dn_rvalid = 1'b0;
    logic [31:0] dn_rdata = 32'h0;
    logic        mabort_set = 1'b0;
    logic        tabort_set = 1'b0;
    logic        cfg_valid, cfg_write, cfg_small, cfg_err, rsp_valid;
    logic [31:0] cfg_addr, cfg_wdata, rsp_data;
    logic [1:0]  cfg_size, abort_stat;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cfgx_translator uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_off(req_off), .req_wdata(req_wdata),
        .map_cfg(map_cfg), .bus_num(bus_num), .dn_rvalid(dn_rvalid),
        .dn_rdata(dn_rdata), .mabort_set(mabort_set), .tabort_set(tabort_set),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_size(cfg_size), .cfg_wdata(cfg_wdata), .cfg_small(cfg_small),
        .cfg_err(cfg_err), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .abort_stat(abort_stat)
    );

    typedef struct packed {
        logic        wr;
        logic [1:0]  sz;
        logic [15:0] off;
        logic [31:0] map;
        logic [7:0]  bus;
        logic [31:0] wd;
        logic [31:0] exp_addr;
        logic        exp_small;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 2'd2, 16'h0104, 32'h0000_0002, 8'h00, 32'hDEAD_BEEF, 32'h8000_3104, 1'b0},
        '{1'b0, 2'd2, 16'h0800, 32'h0000_0000, 8'h05, 32'h0000_0000, 32'h8005_0000, 1'b0},
        '{1'b1, 2'd1, 16'h773C, 32'h0000_0010, 8'hA5, 32'h1234_5678, 32'h80A5_0F3C, 1'b0},
        '{1'b0, 2'd0, 16'h0002, 32'h0000_8000, 8'hFF, 32'h0000_0000, 32'h80FF_A002, 1'b1},
        '{1'b1, 2'd0, 16'h02FF, 32'hFFFE_0001, 8'h00, 32'hCAFE_F00D, 32'h8000_2AFF, 1'b1}
    };

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request across one rising edge; returns at the next falling edge.
    task automatic do_req(input logic wr, input logic [1:0] sz, input logic [15:0] off,
                          input logic [31:0] map, input logic [7:0] bus,
                          input logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_size = sz; req_off = off;
        map_cfg = map; bus_num = bus; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held
        check(!cfg_valid && !cfg_err && !rsp_valid && abort_stat == 2'b00 && cfg_addr == 0,
              "R1 reset outputs", {cfg_valid, cfg_err, rsp_valid, abort_stat}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cfg_valid && !cfg_err && !rsp_valid && rsp_data == 0,
              "R1 after reset", {cfg_valid, cfg_err, rsp_valid}, 0);

        // R2 R3 R6 R7: table of translated accesses
        for (int i = 0; i < NVEC; i++) begin
            do_req(VECS[i].wr, VECS[i].sz, VECS[i].off, VECS[i].map, VECS[i].bus, VECS[i].wd);
            check(cfg_valid === 1'b1 && cfg_err === 1'b0, "R2 issue pulse", {cfg_valid, cfg_err}, 2'b10);
            check(cfg_addr === VECS[i].exp_addr, "R2 R3 config word", cfg_addr, VECS[i].exp_addr);
            check(cfg_small === VECS[i].exp_small, "R6 small flag", cfg_small, VECS[i].exp_small);
            check(cfg_write === VECS[i].wr && cfg_size === VECS[i].sz, "R7 write and size",
                  {cfg_write, cfg_size}, {VECS[i].wr, VECS[i].sz});
            if (VECS[i].wr) check(cfg_wdata === VECS[i].wd, "R7 write data", cfg_wdata, VECS[i].wd);
            @(negedge clk);
            check(cfg_valid === 1'b0, "R2 pulse one cycle", cfg_valid, 0);
        end

        // R4: off window write is dropped
        do_req(1'b1, 2'd2, 16'h0904, 32'h0001_0000, 8'h01, 32'h1111_2222);
        check(!cfg_valid && !cfg_err && !rsp_valid, "R4 off write dropped",
              {cfg_valid, cfg_err, rsp_valid}, 0);
        // R4: off window reads, each size code
        do_req(1'b0, 2'd0, 16'h0904, 32'h0001_0000, 8'h01, 0);
        check(rsp_valid && rsp_data === 32'h0000_00FF && !cfg_valid, "R4 off read byte", rsp_data, 32'hFF);
        do_req(1'b0, 2'd1, 16'h0904, 32'h0001_0000, 8'h01, 0);
        check(rsp_valid && rsp_data === 32'h0000_FFFF, "R4 off read half", rsp_data, 32'hFFFF);
        do_req(1'b0, 2'd2, 16'h0904, 32'h0001_0000, 8'h01, 0);
        check(rsp_valid && rsp_data === 32'hFFFF_FFFF, "R4 off read word", rsp_data, 32'hFFFF_FFFF);
        do_req(1'b0, 2'd3, 16'h0904, 32'h0001_0000, 8'h01, 0);
        check(rsp_valid && rsp_data === 32'hFFFF_FFFF, "R4 off read code3", rsp_data, 32'hFFFF_FFFF);

        // R5: zero device select, write then read
        do_req(1'b1, 2'd2, 16'h0104, 32'h0000_0000, 8'h03, 32'h5555_AAAA);
        check(cfg_err === 1'b1 && cfg_valid === 1'b0 && !rsp_valid, "R5 zero select write",
              {cfg_err, cfg_valid, rsp_valid}, 3'b100);
        @(negedge clk);
        check(cfg_err === 1'b0, "R5 error one cycle", cfg_err, 0);
        do_req(1'b0, 2'd1, 16'h07FF, 32'h0000_0000, 8'h03, 0);
        check(cfg_err && rsp_valid && rsp_data === 32'h0000_FFFF, "R5 zero select read",
              rsp_data, 32'hFFFF);

        // R8: downstream response forwarded one cycle later
        dn_rvalid = 1'b1; dn_rdata = 32'hA5A5_0F0F;
        @(negedge clk);
        dn_rvalid = 1'b0;
        check(rsp_valid && rsp_data === 32'hA5A5_0F0F, "R8 response forward", rsp_data, 32'hA5A5_0F0F);
        @(negedge clk);
        check(!rsp_valid, "R8 response one cycle", rsp_valid, 0);

        // R9: set bits stick and survive off-window and error accesses
        mabort_set = 1'b1; tabort_set = 1'b1;
        @(negedge clk);
        mabort_set = 1'b0; tabort_set = 1'b0;
        @(negedge clk);
        check(abort_stat === 2'b11, "R9 bits sticky", abort_stat, 2'b11);
        do_req(1'b0, 2'd2, 16'h0904, 32'h0001_0000, 8'h00, 0);
        do_req(1'b1, 2'd2, 16'h0004, 32'h0000_0000, 8'h00, 0);
        @(negedge clk);
        check(abort_stat === 2'b11, "R9 kept by off and error", abort_stat, 2'b11);
        // R9: clear after translated access, clear beats a same-cycle set
        do_req(1'b1, 2'd2, 16'h1000, 32'h0000_0000, 8'h00, 0);
        mabort_set = 1'b1; tabort_set = 1'b1;
        @(negedge clk);
        mabort_set = 1'b0; tabort_set = 1'b0;
        check(abort_stat === 2'b00, "R9 clear wins", abort_stat, 2'b00);
        // R9: target bit alone
        tabort_set = 1'b1;
        @(negedge clk);
        tabort_set = 1'b0;
        check(abort_stat === 2'b10, "R9 target bit", abort_stat, 2'b10);

        // R1: reset mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        check(abort_stat === 2'b00 && !rsp_valid, "R1 reset clears status", abort_stat, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule